// File: doc/BRIEF.md
# Delayed-Branch Next-Address Unit

This block holds the fetch address pair of a processor with one branch delay slot: the address of the instruction being fetched now and the address of the instruction that follows it in the slot. Every time the pipeline advances, the block takes one decoded control-transfer request and produces the next pair. The request can be a conditional test on one bit of an operand (taken when that bit is set, or taken when it is clear), an unconditional call relative to the current address, or a jump to a register-based address.

A request may carry an annul flag. When the branch is taken and the flag is set, the delay-slot instruction is skipped: both addresses are loaded straight from the target, and a call links back to the slot address instead of to the word after it. Calls and jumps can write a return address through a one-cycle strobe. A register-based jump whose target is not word-aligned raises an error flag. In that case the pair is held so the exception logic outside the block can take over.

Top module: `dbnu_next_addr`

## Requirements
- R1: While `rst` is high at a clock edge, `fetch_ip` becomes RESET_VEC (default 0x1000), `delay_dp` becomes RESET_VEC+4, and `link_we` and `misalign_err` become 0.
- R2: On an advance with no valid request, or with a request that is not taken, `fetch_ip` takes the old `delay_dp` and `delay_dp` takes the old `delay_dp`+4.
- R3: For kinds 0, 1 and 2 the target is `fetch_ip` + 4 × `br_offset`, with `br_offset` read as a 16-bit two's-complement word count.
- R4: A taken request without annul loads `fetch_ip` with the old `delay_dp` and loads `delay_dp` with the target.
- R5: A taken request with annul loads `fetch_ip` with the target and `delay_dp` with the target+4.
- R6: For kind 2 or kind 3 with `br_link_en` = 1, `link_we` is 1 for the cycle after the advance. `link_value` is then the old `delay_dp`+4 without annul, or the old `delay_dp` with annul. Kinds 0 and 1 never assert `link_we`, whatever `br_link_en` is.
- R7: For kind 3, the target is `br_base` + sign-extended `br_offset` (a byte offset). If its two low bits are not both zero, `misalign_err` is 1 for the cycle after the advance, the pair keeps its value and `link_we` stays 0.
- R8: Kind 0 is taken when bit (31 − `br_bit`) of `br_src` is 1, which is `br_bit` bitwise inverted. Kind 1 is taken when that bit is 0. Kinds 2 and 3 are always taken.
- R9: When `advance` is 0 at an edge, the pair keeps its value, `link_we` and `misalign_err` become 0, and the request is ignored.
- R10: `fetch_ip` and `delay_dp` are always word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Pipeline advances this cycle |
| br_valid | input | 1 | A control-transfer request is present |
| br_kind | input | 2 | 0 bit-set test, 1 bit-clear test, 2 relative call, 3 register jump |
| br_annul | input | 1 | Skip the delay slot when taken |
| br_offset | input | OFS_W (16) | Signed offset (words for kinds 0–2, bytes for kind 3) |
| br_base | input | ADDR_W (32) | Base register value for kind 3 |
| br_src | input | DATA_W (32) | Operand tested by kinds 0 and 1 |
| br_bit | input | 5 | Bit number before inversion |
| br_link_en | input | 1 | Request writes a return address |
| fetch_ip | output | ADDR_W | Address fetched now |
| delay_dp | output | ADDR_W | Delay-slot address |
| link_we | output | 1 | Return-address write strobe |
| link_value | output | ADDR_W | Return address |
| misalign_err | output | 1 | Register-jump target not word-aligned |

## Verification
The alignment property assumes that RESET_VEC is word-aligned. Given that, relative targets stay aligned because the offset is scaled by four, and the only path to an unaligned target is a register jump, which the error check stops. The hold and sequential properties assume the inputs settle before the rising edge. The bench drives every input at the falling edge and uses aligned bases everywhere except in the deliberate misalignment case. The link-value property only accepts the two return addresses the block may choose between, so the bench separately drives calls and jumps both with and without annul to tell the two apart.

// File: rtl/dbnu_pkg.sv
package dbnu_pkg;

    typedef enum logic [1:0] {
        BR_BIT_SET  = 2'd0,
        BR_BIT_CLR  = 2'd1,
        BR_CALL_REL = 2'd2,
        BR_JUMP_REG = 2'd3
    } br_kind_e;

    localparam int INSN_BYTES = 4;
    localparam int INSN_SHIFT = 2;

endpackage

// File: rtl/dbnu_target.sv
module dbnu_target
    import dbnu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 16
) (
    input  logic [ADDR_W-1:0] cur_ip,
    input  logic [OFS_W-1:0]  offset,
    input  logic [ADDR_W-1:0] base,
    input  br_kind_e          kind,
    output logic [ADDR_W-1:0] target,
    output logic              misaligned
);
    localparam int EXT_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] ofs_ext;
    logic [ADDR_W-1:0] rel_tgt;
    logic [ADDR_W-1:0] abs_tgt;

    // sign extension of the offset field to the address width
    assign ofs_ext = {{EXT_W{offset[OFS_W-1]}}, offset};

    // relative forms count in instruction words (R3)
    assign rel_tgt = cur_ip + (ofs_ext << INSN_SHIFT);
    // register form counts in bytes (R7)
    assign abs_tgt = base + ofs_ext;

    always_comb begin
        if (kind == BR_JUMP_REG) begin
            target     = abs_tgt;
            misaligned = |abs_tgt[INSN_SHIFT-1:0];
        end else begin
            target     = rel_tgt;
            misaligned = 1'b0;
        end
    end
endmodule

// File: rtl/dbnu_cond.sv
module dbnu_cond
    import dbnu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src,
    input  logic [BIT_W-1:0]  bit_num,
    input  br_kind_e          kind,
    output logic              taken
);
    logic [BIT_W-1:0] sel_idx;
    logic             sel_bit;

    // bit numbers count from the most significant end (R8)
    assign sel_idx = ~bit_num;
    assign sel_bit = src[sel_idx];

    always_comb begin
        unique case (kind)
            BR_BIT_SET: taken = sel_bit;
            BR_BIT_CLR: taken = ~sel_bit;
            default:    taken = 1'b1;
        endcase
    end
endmodule

// File: rtl/dbnu_link.sv
module dbnu_link
    import dbnu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_dp,
    input  logic              annul,
    input  logic              link_en,
    input  br_kind_e          kind,
    output logic              link_req,
    output logic [ADDR_W-1:0] link_val
);
    logic linking_kind;

    assign linking_kind = (kind == BR_CALL_REL) || (kind == BR_JUMP_REG);
    assign link_req     = link_en && linking_kind;
    // annulled: return to the skipped slot; otherwise past it (R6)
    assign link_val     = annul ? cur_dp : cur_dp + ADDR_W'(INSN_BYTES);
endmodule

// File: rtl/dbnu_next_addr.sv
module dbnu_next_addr
    import dbnu_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          OFS_W     = 16,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] RESET_VEC = 32'h0000_1000,
    localparam int         BIT_W     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              br_valid,
    input  logic [1:0]        br_kind,
    input  logic              br_annul,
    input  logic [OFS_W-1:0]  br_offset,
    input  logic [ADDR_W-1:0] br_base,
    input  logic [DATA_W-1:0] br_src,
    input  logic [BIT_W-1:0]  br_bit,
    input  logic              br_link_en,
    output logic [ADDR_W-1:0] fetch_ip,
    output logic [ADDR_W-1:0] delay_dp,
    output logic              link_we,
    output logic [ADDR_W-1:0] link_value,
    output logic              misalign_err
);
    localparam logic [ADDR_W-1:0] RV_IP = ADDR_W'(RESET_VEC);
    localparam logic [ADDR_W-1:0] RV_DP = ADDR_W'(RESET_VEC) + ADDR_W'(INSN_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] ip;
        logic [ADDR_W-1:0] dp;
        logic              link_we;
        logic [ADDR_W-1:0] link_val;
        logic              err;
    } pc_state_t;

    pc_state_t st_d, st_q;

    br_kind_e          kind;
    logic [ADDR_W-1:0] tgt;
    logic              tgt_bad;
    logic              cond_taken;
    logic              lnk_req;
    logic [ADDR_W-1:0] lnk_val;

    assign kind = br_kind_e'(br_kind);

    dbnu_target #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_target (
        .cur_ip     (st_q.ip),
        .offset     (br_offset),
        .base       (br_base),
        .kind       (kind),
        .target     (tgt),
        .misaligned (tgt_bad)
    );

    dbnu_cond #(.DATA_W(DATA_W)) u_cond (
        .src     (br_src),
        .bit_num (br_bit),
        .kind    (kind),
        .taken   (cond_taken)
    );

    dbnu_link #(.ADDR_W(ADDR_W)) u_link (
        .cur_dp   (st_q.dp),
        .annul    (br_annul),
        .link_en  (br_link_en),
        .kind     (kind),
        .link_req (lnk_req),
        .link_val (lnk_val)
    );

    always_comb begin
        st_d          = st_q;
        st_d.link_we  = 1'b0;
        st_d.err      = 1'b0;
        if (advance) begin
            if (br_valid && tgt_bad) begin
                // hold the pair, flag the fault (R7)
                st_d.err = 1'b1;
            end else if (br_valid && cond_taken) begin
                if (br_annul) begin
                    st_d.ip = tgt;
                    st_d.dp = tgt + ADDR_W'(INSN_BYTES);
                end else begin
                    st_d.ip = st_q.dp;
                    st_d.dp = tgt;
                end
                if (lnk_req) begin
                    st_d.link_we  = 1'b1;
                    st_d.link_val = lnk_val;
                end
            end else begin
                st_d.ip = st_q.dp;
                st_d.dp = st_q.dp + ADDR_W'(INSN_BYTES);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ip       <= RV_IP;
            st_q.dp       <= RV_DP;
            st_q.link_we  <= 1'b0;
            st_q.link_val <= '0;
            st_q.err      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_ip     = st_q.ip;
    assign delay_dp     = st_q.dp;
    assign link_we      = st_q.link_we;
    assign link_value   = st_q.link_val;
    assign misalign_err = st_q.err;
endmodule

// File: rtl/dbnu_checker.sv
module dbnu_checker #(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
    input logic              clk,
    input logic              rst,
    input logic              advance,
    input logic              br_valid,
    input logic [ADDR_W-1:0] fetch_ip,
    input logic [ADDR_W-1:0] delay_dp,
    input logic              link_we,
    input logic [ADDR_W-1:0] link_value,
    input logic              misalign_err
);
    localparam logic [ADDR_W-1:0] FOUR = ADDR_W'(4);

    assert_reset_pair_R1: assert property (@(posedge clk)
        rst |=> (fetch_ip == ADDR_W'(RESET_VEC)) && !link_we && !misalign_err);

    assert_sequential_R2: assert property (@(posedge clk) disable iff (rst)
        (advance && !br_valid) |=>
            (fetch_ip == $past(delay_dp)) && (delay_dp == $past(delay_dp) + FOUR));

    assert_link_choice_R6: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_value == $past(delay_dp)) || (link_value == $past(delay_dp) + FOUR));

    assert_fault_holds_R7: assert property (@(posedge clk) disable iff (rst)
        misalign_err |-> $stable(fetch_ip) && $stable(delay_dp) && !link_we);

    assert_stall_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(fetch_ip) && $stable(delay_dp) && !link_we && !misalign_err);

    assert_aligned_R10: assert property (@(posedge clk) disable iff (rst)
        (fetch_ip[1:0] == 2'b00) && (delay_dp[1:0] == 2'b00));
endmodule

bind dbnu_next_addr dbnu_checker #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .advance      (advance),
    .br_valid     (br_valid),
    .fetch_ip     (fetch_ip),
    .delay_dp     (delay_dp),
    .link_we      (link_we),
    .link_value   (link_value),
    .misalign_err (misalign_err)
);

// File: tb/dbnu_next_addr_test.sv
module dbnu_next_addr_test;
    localparam logic [31:0] RV = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        advance = 1'b0;
    logic        br_valid = 1'b0;
    logic [1:0]  br_kind = 2'd0;
    logic        br_annul = 1'b0;
    logic [15:0] br_offset = '0;
    logic [31:0] br_base = '0;
    logic [31:0] br_src = '0;
    logic [4:0]  br_bit = '0;
    logic        br_link_en = 1'b0;
    logic [31:0] fetch_ip, delay_dp, link_value;
    logic        link_we, misalign_err;

    always #4 clk = ~clk;

    dbnu_next_addr uut (
        .clk(clk), .rst(rst), .advance(advance), .br_valid(br_valid),
        .br_kind(br_kind), .br_annul(br_annul), .br_offset(br_offset),
        .br_base(br_base), .br_src(br_src), .br_bit(br_bit),
        .br_link_en(br_link_en), .fetch_ip(fetch_ip), .delay_dp(delay_dp),
        .link_we(link_we), .link_value(link_value), .misalign_err(misalign_err)
    );

    typedef struct packed {
        logic        valid;
        logic [1:0]  kind;
        logic        annul;
        logic        link_en;
        logic [15:0] ofs;
        logic [31:0] base;
        logic [31:0] src;
        logic [4:0]  bsel;
        logic        exp_taken;
        logic        exp_err;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 1'b0, 1'b0, 16'h0000, 32'h0,         32'h0,         5'd0,  1'b0, 1'b0}, // R2 idle
        '{1'b1, 2'd0, 1'b0, 1'b0, 16'h0010, 32'h0,         32'h8000_0000, 5'd0,  1'b1, 1'b0}, // R8 bit31 set
        '{1'b1, 2'd0, 1'b0, 1'b0, 16'h0010, 32'h0,         32'h0000_0001, 5'd0,  1'b0, 1'b0}, // R8 bit31 clear
        '{1'b1, 2'd1, 1'b1, 1'b0, 16'hFFF8, 32'h0,         32'h0000_0000, 5'd31, 1'b1, 1'b0}, // R3 R5 neg ofs
        '{1'b1, 2'd1, 1'b0, 1'b0, 16'h0004, 32'h0,         32'h0000_0001, 5'd31, 1'b0, 1'b0}, // R8 bit0 set
        '{1'b1, 2'd2, 1'b0, 1'b1, 16'h0020, 32'h0,         32'h0,         5'd0,  1'b1, 1'b0}, // R6 call
        '{1'b1, 2'd2, 1'b1, 1'b1, 16'hFFFC, 32'h0,         32'h0,         5'd0,  1'b1, 1'b0}, // R6 call annul
        '{1'b1, 2'd3, 1'b0, 1'b1, 16'h0010, 32'h0000_2000, 32'h0,         5'd0,  1'b1, 1'b0}, // R7 jump
        '{1'b1, 2'd3, 1'b0, 1'b1, 16'h0000, 32'h0000_2002, 32'h0,         5'd0,  1'b0, 1'b1}, // R7 misaligned
        '{1'b1, 2'd3, 1'b1, 1'b0, 16'hFF00, 32'h0000_3000, 32'h0,         5'd0,  1'b1, 1'b0}, // R7 R5 jump annul
        '{1'b1, 2'd0, 1'b1, 1'b1, 16'h0008, 32'h0,         32'h0400_0000, 5'd5,  1'b1, 1'b0}, // R8 bit26, R6 no link
        '{1'b1, 2'd0, 1'b0, 1'b0, 16'h0008, 32'h0,         32'h0000_0020, 5'd5,  1'b0, 1'b0}, // R8 raw bit5 ignored
        '{1'b1, 2'd2, 1'b0, 1'b0, 16'h0002, 32'h0,         32'h0,         5'd0,  1'b1, 1'b0}  // R4 call no link
    };

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] m_ip, m_dp;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v, input logic adv);
        logic [31:0] ox, tgt, e_ip, e_dp, e_lv;
        logic e_lw, e_err;
        string tag;
        advance = adv; br_valid = v.valid; br_kind = v.kind; br_annul = v.annul;
        br_offset = v.ofs; br_base = v.base; br_src = v.src; br_bit = v.bsel;
        br_link_en = v.link_en;
        ox  = {{16{v.ofs[15]}}, v.ofs};
        tgt = (v.kind == 2'd3) ? v.base + ox : m_ip + (ox << 2);  // R3 / R7
        e_ip = m_dp; e_dp = m_dp + 32'd4; e_lw = 1'b0; e_lv = 32'h0; e_err = 1'b0;
        tag = "R2";
        if (!adv) begin
            e_ip = m_ip; e_dp = m_dp; tag = "R9";
        end else if (v.valid && v.exp_err) begin
            e_ip = m_ip; e_dp = m_dp; e_err = 1'b1; tag = "R7";
        end else if (v.valid && v.exp_taken) begin
            if (v.annul) begin
                e_ip = tgt; e_dp = tgt + 32'd4; tag = "R5";
            end else begin
                e_ip = m_dp; e_dp = tgt; tag = "R4";
            end
            if (v.link_en && v.kind[1]) begin
                e_lw = 1'b1;
                e_lv = v.annul ? m_dp : m_dp + 32'd4;
            end
        end
        @(negedge clk);
        chk({tag, " ip"}, fetch_ip, e_ip);
        chk({tag, " dp"}, delay_dp, e_dp);
        chk("R6 link_we", {31'b0, link_we}, {31'b0, e_lw});
        if (e_lw) chk("R6 link_value", link_value, e_lv);
        chk("R7 misalign_err", {31'b0, misalign_err}, {31'b0, e_err});
        m_ip = e_ip; m_dp = e_dp;
    endtask

    task automatic check_reset();
        chk("R1 ip", fetch_ip, RV);
        chk("R1 dp", delay_dp, RV + 32'd4);
        chk("R1 link_we", {31'b0, link_we}, 32'd0);
        chk("R1 err", {31'b0, misalign_err}, 32'd0);
        m_ip = RV; m_dp = RV + 32'd4;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_reset();
        rst = 1'b0;

        for (int i = 0; i < NV; i++) apply(VECS[i], 1'b1);

        // R9: stalled call with link must change nothing
        apply(VECS[5], 1'b0);
        apply(VECS[6], 1'b0);
        // resumes normally afterwards
        apply(VECS[5], 1'b1);
        // R7: misaligned jump with link enabled never links, repeated
        apply(VECS[8], 1'b1);
        apply(VECS[8], 1'b1);
        apply(VECS[0], 1'b1);

        // R1: reset in the middle of a run
        advance = 1'b1; br_valid = 1'b1; br_kind = 2'd2; br_link_en = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check_reset();
        rst = 1'b0;
        apply(VECS[7], 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule